// File: doc/BRIEF.md
# Sector Timer Event Generator

This block runs a free-counting sector timer on the data clock and derives a set of timed events from it. A bank of compare registers is checked against the timer on every clock. A match on one of the data-sector slots starts a sector pulse. A match on the index slot starts an index pulse. A match on the power-on slot gives a one-clock power-on pulse. A match on the PWM slot drives the dedicated PWM output high until the timer is next reset. A match on the search slot opens the search window.

The sequencer resets the timer each time a timing mark is found. On that reset the block captures the timer's value so that the host can read it later. The host programs the block over a simple synchronous register bus and controls the timer with an enable bit. The search window can be opened by the host or by the search compare. It can be closed by the host or by the sequencer, and a close always wins over an open. A missing-mark flag, together with a configuration bit, can suppress the sector and index pulses.

Top module: `sector_event_gen`

## Requirements
- R1: After reset, every event output is low, and the live timer (address 24) and the captured value (address 23) both read 0.
- R2: While the enable bit (bit 0 at address 21) is 1, the timer advances by one on every clock. While that bit is 0, the timer is held at 0.
- R3: When `mark_reset` is high on a clock while the timer is enabled, the timer's current value goes into the capture register (address 23) and the timer restarts from 0.
- R4: Sector compare slots 0 to 7 sit at addresses 0 to 7. When the timer equals any nonzero slot value, `sector_pulse` rises on the next clock and stays high for (W*4)+1 clocks, where W is bits 2:0 at address 20.
- R5: A compare slot that holds 0 never produces its event.
- R6: When W is 0, neither `sector_pulse` nor `index_pulse` is ever produced.
- R7: When the block bit (bit 3 at address 20) is 1 and `missing_mark` is high, matches do not start sector or index pulses. When `missing_mark` is low, the pulses are produced as usual.
- R8: The index compare (address 16) starts `index_pulse` with the same timing and width as the sector pulse.
- R9: A power-on compare match (address 17) gives a single-clock `power_on_pulse` on the following clock. A PWM compare match (address 18) sets `pwm_out` from the following clock until the timer is reset or disabled.
- R10: A search compare match (address 19) sets `search_win` on the following clock.
- R11: Writing 1 to bit 1 at address 21 sets `search_win`. Writing 0 to that bit leaves the window unchanged.
- R12: `seq_srch_clr` clears `search_win` on the next clock, and so does writing 1 to bit 0 at address 22. A clear on the same clock as a set leaves the window low. Address 22 reads the window on bit 0.
- R13: Compare slots that hold the same value fire their events on the same clock.
- R14: With no reset, the timer wraps from 0xFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| mark_reset | input | 1 | Timing-mark reset of the timer from the sequencer |
| seq_srch_clr | input | 1 | Search-window clear from the sequencer |
| missing_mark | input | 1 | Missing-timing-mark latch state |
| sector_pulse | output | 1 | Data-sector pulse |
| index_pulse | output | 1 | Index pulse |
| power_on_pulse | output | 1 | One-clock power-on pulse |
| pwm_out | output | 1 | Dedicated PWM output |
| search_win | output | 1 | Search window |

## Verification
Every event is timed from the one timer, so a wrong timer value shows up within one clock. It appears on the live-timer read, and every later pulse edge moves by the same offset. A pulse counter that loads the wrong width or misses a retrigger shows up as a sector or index pulse whose first or last high clock is off. A wrong priority or decode in the search-window flop shows up on `search_win` on the clock after the set or clear.

// File: rtl/sev_pkg.sv
package sev_pkg;

   // register map (bus word addresses)
   localparam int unsigned A_INDEX = 16;
   localparam int unsigned A_PWRON = 17;
   localparam int unsigned A_PWM   = 18;
   localparam int unsigned A_SRCH  = 19;
   localparam int unsigned A_CFG   = 20;
   localparam int unsigned A_CTRL  = 21;
   localparam int unsigned A_STAT  = 22;
   localparam int unsigned A_CAPT  = 23;
   localparam int unsigned A_LIVE  = 24;

   // control bit positions
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_OPEN_BIT = 1;
   localparam int unsigned STAT_CLR_BIT  = 0;

   // named extra compare slots, offset from the sector count
   typedef enum int unsigned {
      X_INDEX = 0,
      X_PWRON = 1,
      X_PWM   = 2,
      X_SRCH  = 3
   } extra_slot_e;

   localparam int unsigned N_EXTRA = 4;

   // bus address of compare slot i when there are ns sector slots
   function automatic int unsigned slot_addr(int unsigned i, int unsigned ns);
      if (i < ns) return i;
      return A_INDEX + (i - ns);
   endfunction

endpackage

// File: rtl/sev_timer.sv
module sev_timer #(
   parameter int unsigned TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          mark_reset,
   output logic [TW-1:0] tmr,
   output logic [TW-1:0] cap
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr <= '0;
         cap <= '0;
      end else if (!en) begin
         tmr <= '0;
      end else if (mark_reset) begin
         cap <= tmr;
         tmr <= '0;
      end else begin
         tmr <= tmr + TW'(1);
      end
   end

endmodule

// File: rtl/sev_regs.sv
module sev_regs
   import sev_pkg::*;
#(
   parameter int unsigned TW    = 16,
   parameter int unsigned AW    = 5,
   parameter int unsigned NS    = 8,
   parameter int unsigned WFW   = 3,
   localparam int unsigned NCMP = NS + N_EXTRA
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_we,
   input  logic [AW-1:0]            bus_addr,
   input  logic [TW-1:0]            bus_wdata,
   output logic [NCMP-1:0][TW-1:0]  cmp_val,
   output logic [WFW-1:0]           wfield,
   output logic                     blk_en,
   output logic                     tmr_en,
   output logic                     open_set,
   output logic                     stat_clr
);

   logic wr_cfg, wr_ctrl, wr_stat;

   assign wr_cfg  = bus_we && (bus_addr == AW'(A_CFG));
   assign wr_ctrl = bus_we && (bus_addr == AW'(A_CTRL));
   assign wr_stat = bus_we && (bus_addr == AW'(A_STAT));

   // one register per compare slot
   for (genvar i = 0; i < NCMP; i++) begin : g_cmp_reg
      localparam int unsigned ADDR = slot_addr(i, NS);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_val[i] <= '0;
         else if (bus_we && (bus_addr == AW'(ADDR)))
            cmp_val[i] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wfield <= '0;
         blk_en <= 1'b0;
      end else if (wr_cfg) begin
         wfield <= bus_wdata[WFW-1:0];
         blk_en <= bus_wdata[WFW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmr_en <= 1'b0;
      else if (wr_ctrl)
         tmr_en <= bus_wdata[CTRL_EN_BIT];
   end

   // single-cycle strobes, a written 0 does nothing
   assign open_set = wr_ctrl && bus_wdata[CTRL_OPEN_BIT];
   assign stat_clr = wr_stat && bus_wdata[STAT_CLR_BIT];

endmodule

// File: rtl/sev_cmp.sv
module sev_cmp #(
   parameter int unsigned TW   = 16,
   parameter int unsigned NCMP = 12
) (
   input  logic                    en,
   input  logic [TW-1:0]           tmr,
   input  logic [NCMP-1:0][TW-1:0] cmp_val,
   output logic [NCMP-1:0]         hit
);

   // a zero slot is disabled; all slots compare in parallel
   for (genvar i = 0; i < NCMP; i++) begin : g_slot
      assign hit[i] = en && (cmp_val[i] != '0) && (tmr == cmp_val[i]);
   end

endmodule

// File: rtl/sev_pulse.sv
module sev_pulse #(
   parameter int unsigned WFW  = 3,
   localparam int unsigned CW  = WFW + 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trig,
   input  logic [WFW-1:0] wfield,
   output logic           pulse
);

   logic [CW-1:0] cnt;
   logic [CW-1:0] load_val;

   // width = field*4 + 1 clocks
   assign load_val = {wfield, 2'b00} + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (trig && (wfield != '0))
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   assign pulse = (cnt != '0);

endmodule

// File: rtl/sev_search.sv
module sev_search (
   input  logic clk,
   input  logic rst_n,
   input  logic set_cmp,
   input  logic set_host,
   input  logic clr_seq,
   input  logic clr_host,
   output logic win
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win <= 1'b0;
      else if (clr_seq || clr_host)
         win <= 1'b0;
      else if (set_cmp || set_host)
         win <= 1'b1;
   end

endmodule

// File: rtl/sector_event_gen.sv
module sector_event_gen
   import sev_pkg::*;
#(
   parameter int unsigned TW  = 16,
   parameter int unsigned AW  = 5,
   parameter int unsigned NS  = 8,
   parameter int unsigned WFW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [TW-1:0] bus_wdata,
   output logic [TW-1:0] bus_rdata,
   input  logic          mark_reset,
   input  logic          seq_srch_clr,
   input  logic          missing_mark,
   output logic          sector_pulse,
   output logic          index_pulse,
   output logic          power_on_pulse,
   output logic          pwm_out,
   output logic          search_win
);

   localparam int unsigned NCMP     = NS + N_EXTRA;
   localparam int unsigned I_INDEX  = NS + X_INDEX;
   localparam int unsigned I_PWRON  = NS + X_PWRON;
   localparam int unsigned I_PWM    = NS + X_PWM;
   localparam int unsigned I_SRCH   = NS + X_SRCH;

   // elaboration-time parameter checks
   if (NS < 1 || NS > A_INDEX) begin : g_bad_ns
      $error("sector_event_gen: NS must lie in 1..16");
   end
   if (AW < 5) begin : g_bad_aw
      $error("sector_event_gen: AW must be at least 5");
   end
   if (TW < WFW + 1 || TW < 4) begin : g_bad_tw
      $error("sector_event_gen: TW too narrow for config fields");
   end
   if (WFW < 1 || WFW > 6) begin : g_bad_wfw
      $error("sector_event_gen: WFW must lie in 1..6");
   end

   logic [NCMP-1:0][TW-1:0] cmp_val;
   logic [NCMP-1:0]         hit;
   logic [WFW-1:0]          wfield;
   logic                    blk_en, tmr_en, open_set, stat_clr;
   logic [TW-1:0]           tmr_val, cap_val;
   logic                    suppress, sec_trig, idx_trig;
   logic                    pwr_q, pwm_q;

   sev_regs #(.TW(TW), .AW(AW), .NS(NS), .WFW(WFW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cmp_val   (cmp_val),
      .wfield    (wfield),
      .blk_en    (blk_en),
      .tmr_en    (tmr_en),
      .open_set  (open_set),
      .stat_clr  (stat_clr)
   );

   sev_timer #(.TW(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (tmr_en),
      .mark_reset (mark_reset),
      .tmr        (tmr_val),
      .cap        (cap_val)
   );

   sev_cmp #(.TW(TW), .NCMP(NCMP)) u_cmp (
      .en      (tmr_en),
      .tmr     (tmr_val),
      .cmp_val (cmp_val),
      .hit     (hit)
   );

   // sector/index pulses are withheld while the mark is missing
   assign suppress = blk_en && missing_mark;
   assign sec_trig = (|hit[NS-1:0]) && !suppress;
   assign idx_trig = hit[I_INDEX] && !suppress;

   sev_pulse #(.WFW(WFW)) u_sec_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (sec_trig),
      .wfield (wfield),
      .pulse  (sector_pulse)
   );

   sev_pulse #(.WFW(WFW)) u_idx_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (idx_trig),
      .wfield (wfield),
      .pulse  (index_pulse)
   );

   sev_search u_search (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_cmp  (hit[I_SRCH]),
      .set_host (open_set),
      .clr_seq  (seq_srch_clr),
      .clr_host (stat_clr),
      .win      (search_win)
   );

   // power-on strobe and PWM level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q <= 1'b0;
         pwm_q <= 1'b0;
      end else begin
         pwr_q <= hit[I_PWRON];
         if (!tmr_en || mark_reset)
            pwm_q <= 1'b0;
         else if (hit[I_PWM])
            pwm_q <= 1'b1;
      end
   end

   assign power_on_pulse = pwr_q;
   assign pwm_out        = pwm_q;

   // read mux
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NCMP; i++) begin
         if (bus_addr == AW'(slot_addr(i, NS)))
            bus_rdata = cmp_val[i];
      end
      case (bus_addr)
         AW'(A_CFG):  bus_rdata = TW'({blk_en, wfield});
         AW'(A_CTRL): bus_rdata = TW'(tmr_en);
         AW'(A_STAT): bus_rdata = TW'(search_win);
         AW'(A_CAPT): bus_rdata = cap_val;
         AW'(A_LIVE): bus_rdata = tmr_val;
         default: ;
      endcase
   end

endmodule

// File: rtl/sev_chk.sv
module sev_chk #(
   parameter int unsigned TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          mark_reset,
   input logic [TW-1:0] tmr,
   input logic [TW-1:0] cap,
   input logic          seq_srch_clr,
   input logic          search_win,
   input logic          pwm_out,
   input logic          power_on_pulse
);

   assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (tmr == '0));

   assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !mark_reset) |=> (tmr == $past(tmr) + TW'(1)));

   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mark_reset) |=> ((cap == $past(tmr)) && (tmr == '0)));

   assert_pwr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      power_on_pulse |=> !power_on_pulse);

   assert_pwm_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || mark_reset) |=> !pwm_out);

   assert_srch_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      seq_srch_clr |=> !search_win);

endmodule

bind sector_event_gen sev_chk #(.TW(TW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .en             (tmr_en),
   .mark_reset     (mark_reset),
   .tmr            (tmr_val),
   .cap            (cap_val),
   .seq_srch_clr   (seq_srch_clr),
   .search_win     (search_win),
   .pwm_out        (pwm_out),
   .power_on_pulse (power_on_pulse)
);

// File: tb/tb_sector_event_gen.sv
module tb_sector_event_gen;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int TW = 16;

   localparam logic [AW-1:0] R_IDX  = 5'd16;
   localparam logic [AW-1:0] R_PWR  = 5'd17;
   localparam logic [AW-1:0] R_PWM  = 5'd18;
   localparam logic [AW-1:0] R_SRC  = 5'd19;
   localparam logic [AW-1:0] R_CFG  = 5'd20;
   localparam logic [AW-1:0] R_CTL  = 5'd21;
   localparam logic [AW-1:0] R_STA  = 5'd22;
   localparam logic [AW-1:0] R_CAP  = 5'd23;
   localparam logic [AW-1:0] R_LIVE = 5'd24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [TW-1:0] bus_wdata = '0;
   logic [TW-1:0] bus_rdata;
   logic mark_reset = 1'b0, seq_srch_clr = 1'b0, missing_mark = 1'b0;
   logic sector_pulse, index_pulse, power_on_pulse, pwm_out, search_win;

   int checks = 0;
   int errors = 0;
   logic [63:0] hs, hx, hp, hw, hr;
   int bad_tmr;

   always #(CLK_PERIOD/2) clk = ~clk;

   sector_event_gen dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mark_reset(mark_reset),
      .seq_srch_clr(seq_srch_clr), .missing_mark(missing_mark),
      .sector_pulse(sector_pulse), .index_pulse(index_pulse),
      .power_on_pulse(power_on_pulse), .pwm_out(pwm_out),
      .search_win(search_win)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] rng(input int lo, input int hi);
      logic [63:0] m = '0;
      for (int i = lo; i <= hi; i++) m[i] = 1'b1;
      return m;
   endfunction

   // write; returns at the falling edge after the capturing edge
   task automatic wr(input logic [AW-1:0] a, input logic [TW-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic clear_all();
      wr(R_CTL, 16'h0);
      for (int i = 0; i < 8; i++) wr(AW'(i), 16'h0);
      wr(R_IDX, 16'h0); wr(R_PWR, 16'h0); wr(R_PWM, 16'h0); wr(R_SRC, 16'h0);
      wr(R_STA, 16'h1);
   endtask

   // enable the timer, then sample outputs after each of n edges
   task automatic run_collect(input int n);
      hs = '0; hx = '0; hp = '0; hw = '0; hr = '0; bad_tmr = 0;
      wr(R_CTL, 16'h1);
      bus_addr = R_LIVE;
      for (int k = 1; k <= n; k++) begin
         @(posedge clk); @(negedge clk);
         hs[k] = sector_pulse; hx[k] = index_pulse; hp[k] = power_on_pulse;
         hw[k] = pwm_out; hr[k] = search_win;
         if (bus_rdata != TW'(k)) bad_tmr++;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 outputs", {59'd0, sector_pulse, index_pulse, power_on_pulse, pwm_out, search_win}, 64'd0);
      bus_addr = R_LIVE; #1;
      chk("R1 live timer", 64'(bus_rdata), 64'd0);
      bus_addr = R_CAP; #1;
      chk("R1 capture", 64'(bus_rdata), 64'd0);
   endtask

   task automatic t_main();
      clear_all();
      wr(R_CFG, 16'h1);
      wr(5'd0, 16'd5); wr(5'd3, 16'd12);
      wr(R_IDX, 16'd12); wr(R_PWR, 16'd7); wr(R_PWM, 16'd9); wr(R_SRC, 16'd20);
      run_collect(25);
      chk("R2 timer counts", 64'(bad_tmr), 64'd0);
      chk("R4 sector pulses", hs, rng(6, 10) | rng(13, 17));
      chk("R8 index pulse", hx, rng(13, 17));
      chk("R13 same-value events", hs & hx, rng(13, 17));
      chk("R9 power-on", hp, rng(8, 8));
      chk("R9 pwm", hw, rng(10, 25));
      chk("R10 search compare", hr, rng(21, 25));
      wr(R_CTL, 16'h0);
      repeat (3) @(posedge clk);
      @(negedge clk); bus_addr = R_LIVE; #1;
      chk("R2 held at zero", 64'(bus_rdata), 64'd0);
   endtask

   task automatic t_width();
      clear_all();
      wr(R_CFG, 16'h0); wr(5'd0, 16'd5); wr(R_IDX, 16'd5);
      run_collect(12);
      chk("R6 width zero", hs | hx, 64'd0);
      clear_all();
      wr(R_CFG, 16'h7); wr(5'd2, 16'd4);
      run_collect(40);
      chk("R4 max width", hs, rng(5, 33));
      clear_all();
      wr(R_CFG, 16'h1);
      run_collect(12);
      chk("R5 zero slots", hs | hx | hp | hw | hr, 64'd0);
   endtask

   task automatic t_block();
      clear_all();
      wr(R_CFG, 16'h9); wr(5'd0, 16'd5); wr(R_IDX, 16'd5);
      missing_mark = 1'b1;
      run_collect(12);
      chk("R7 blocked", hs | hx, 64'd0);
      wr(R_CTL, 16'h0);
      missing_mark = 1'b0;
      run_collect(12);
      chk("R7 unblocked", hs & hx, rng(6, 10));
   endtask

   task automatic t_capture();
      clear_all();
      wr(R_PWM, 16'd3);
      run_collect(10);
      chk("R9 pwm before mark", 64'(hw[10]), 64'd1);
      mark_reset = 1'b1;
      @(posedge clk); @(negedge clk);
      mark_reset = 1'b0;
      bus_addr = R_CAP; #1;
      chk("R3 captured value", 64'(bus_rdata), 64'd10);
      bus_addr = R_LIVE; #1;
      chk("R3 timer restarted", 64'(bus_rdata), 64'd0);
      chk("R9 pwm cleared by mark", 64'(pwm_out), 64'd0);
      @(posedge clk); @(negedge clk);
      chk("R3 counts after mark", 64'(bus_rdata), 64'd1);
   endtask

   task automatic t_search();
      clear_all();
      wr(R_CTL, 16'h2);
      chk("R11 open bit sets", 64'(search_win), 64'd1);
      wr(R_CTL, 16'h0);
      chk("R11 write 0 no effect", 64'(search_win), 64'd1);
      bus_addr = R_STA; #1;
      chk("R12 status read", 64'(bus_rdata[0]), 64'd1);
      wr(R_STA, 16'h1);
      chk("R12 host clear", 64'(search_win), 64'd0);
      wr(R_CTL, 16'h2);
      @(negedge clk); seq_srch_clr = 1'b1;
      @(posedge clk); @(negedge clk); seq_srch_clr = 1'b0;
      chk("R12 sequencer clear", 64'(search_win), 64'd0);
      @(negedge clk);
      seq_srch_clr = 1'b1; bus_we = 1'b1; bus_addr = R_CTL; bus_wdata = 16'h2;
      @(posedge clk); @(negedge clk);
      seq_srch_clr = 1'b0; bus_we = 1'b0;
      chk("R12 clear beats set", 64'(search_win), 64'd0);
   endtask

   task automatic t_wrap();
      clear_all();
      wr(R_CTL, 16'h1);
      bus_addr = R_LIVE;
      repeat (65535) @(posedge clk);
      @(negedge clk);
      chk("R14 top value", 64'(bus_rdata), 64'hFFFF);
      @(posedge clk); @(negedge clk);
      chk("R14 wrap to zero", 64'(bus_rdata), 64'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_main();
      t_width();
      t_block();
      t_capture();
      t_search();
      t_wrap();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule